// File: doc/BRIEF.md
# Auto-incrementing video memory data port

This block gives a host processor byte-wide access to a 512 KB video memory through one data port. Two 19-bit pointers are kept, one for stores and one for loads. Each is set by three byte-sized register writes: low byte, middle byte and a top byte. The top byte supplies address bits 18:16 and a flag that freezes that pointer. After each data transfer the pointer steps to the next byte unless it is frozen, so the host can stream a run of bytes without reloading the address.

Loads never go straight to memory. The block keeps a one-byte prefetch buffer and the data port always presents that buffer. Loading the read pointer's top byte, or a data read that advances the pointer, starts a refill from the pointer's new address. The refill drives the memory's address lines for one cycle and latches the returned byte one cycle later. Because of this buffer, reading address A and writing that byte to A+1 cannot spread one value across a block of memory. A system-reset input puts the port in a mode where data stores are dropped and data reads change nothing.

The memory side is a plain synchronous RAM interface. The block supplies the address, write enable and write data, and the read data arrives on the cycle after the address.

Top module: `vram_port`

## Requirements
- R1: After reset both pointers are 0, both freeze flags are clear, the buffer (and so `data_rdata`) holds 0, and `busy` is low.
- R2: `reg_sel` picks the register a `reg_we` strobe loads: 0 store-low, 1 store-middle, 2 store-top, 3 load-low, 4 load-middle, 5 load-top, and 6 and 7 do nothing. A pointer is {top[2:0], middle, low}. Bit 7 of a top byte is that pointer's freeze flag.
- R3: A `data_we` strobe puts `mem_addr` = store pointer, `mem_we` = 1 and `mem_wdata` = `data_wdata` in that same cycle. If the store pointer is not frozen, it then advances by one.
- R4: While the store pointer's freeze flag is set, successive stores hit the same address.
- R5: Advancing carries from the low byte into the middle byte and from the middle byte into the top bits, and wraps from 0x7FFFF to 0x00000.
- R6: `data_rdata` always shows the buffer. A `data_re` strobe with the load pointer not frozen advances the pointer and starts a refill. `busy` is high for exactly the two cycles after the strobe, and the buffer holds the byte at the new address when `busy` falls.
- R7: Writing the load-top register loads the pointer and refills the buffer from that address with the same two-cycle `busy`. Writing load-low or load-middle starts no refill.
- R8: A `data_re` strobe while the load pointer is frozen leaves the pointer and the buffer unchanged and starts no refill.
- R9: Reading address A and storing the result at A+1 does not copy the byte forward. The next read returns the old contents of A+1.
- R10: While `sys_reset` is high, `data_we` causes no memory write and no pointer step, and `data_re` changes neither the pointer nor the buffer and raises no `busy`.
- R11: Host strobes are ignored while `busy` is high. In a cycle where `reg_we` is set, any `data_we` or `data_re` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_reset | input | 1 | System-reset mode, level |
| reg_we | input | 1 | Pointer register write strobe |
| reg_sel | input | 3 | Pointer register select |
| reg_wdata | input | 8 | Pointer register write byte |
| data_we | input | 1 | Data port write strobe |
| data_wdata | input | 8 | Data port write byte |
| data_re | input | 1 | Data port read strobe |
| data_rdata | output | 8 | Prefetch buffer contents |
| busy | output | 1 | Refill in progress |
| mem_addr | output | 19 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after address |

## Verification
The bench targets the carries out of the low byte and the middle byte and the wrap at the top of memory. A design with a short carry chain would write to the wrong 64 KB bank or to an address past the top. It checks that a frozen pointer stays put on both the store and the load side, and that a frozen load also skips the refill: an extra refill would be harmless to the data but would raise `busy`. The copy-forward pattern catches a design that reads memory directly instead of through the buffer. The system-reset and busy-window cases catch a design that lets dropped strobes still step a pointer or overwrite a location.

// File: rtl/vram_port.sv
module vram_port #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_reset,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          data_we,
  input  logic [7:0]    data_wdata,
  input  logic          data_re,
  output logic [7:0]    data_rdata,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  localparam int TW = AW - 16;

  typedef enum logic [1:0] {IDLE, ISSUE, LATCH} fill_t;

  fill_t         fill_q;
  logic [AW-1:0] wptr, rptr;
  logic          wfrz, rfrz;
  logic [7:0]    buf_q;

  wire host_ok  = (fill_q == IDLE);
  wire reg_go   = reg_we & host_ok;
  wire store_go = data_we & host_ok & ~reg_we & ~sys_reset;
  wire load_go  = data_re & host_ok & ~reg_we & ~sys_reset;
  wire refill   = (reg_go & (reg_sel == 3'd5)) | (load_go & ~rfrz);

  assign busy       = ~host_ok;
  assign data_rdata = buf_q;
  assign mem_we     = store_go;
  assign mem_wdata  = data_wdata;
  assign mem_addr   = (fill_q == ISSUE) ? rptr : wptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      wfrz <= 1'b0;
      rfrz <= 1'b0;
    end else if (reg_go) begin
      case (reg_sel)
        3'd0: wptr[7:0]   <= reg_wdata;
        3'd1: wptr[15:8]  <= reg_wdata;
        3'd2: begin
          wptr[AW-1:16] <= reg_wdata[TW-1:0];
          wfrz          <= reg_wdata[7];
        end
        3'd3: rptr[7:0]   <= reg_wdata;
        3'd4: rptr[15:8]  <= reg_wdata;
        3'd5: begin
          rptr[AW-1:16] <= reg_wdata[TW-1:0];
          rfrz          <= reg_wdata[7];
        end
        default: ;
      endcase
    end else begin
      if (store_go && !wfrz) wptr <= wptr + 1'b1;
      if (load_go && !rfrz)  rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= IDLE;
      buf_q  <= '0;
    end else begin
      case (fill_q)
        IDLE:  if (refill) fill_q <= ISSUE;
        ISSUE: fill_q <= LATCH;
        LATCH: begin
          buf_q  <= mem_rdata;
          fill_q <= IDLE;
        end
        default: fill_q <= IDLE;
      endcase
    end
  end
endmodule

module vram_port_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sys_reset,
  input logic          reg_we,
  input logic [2:0]    reg_sel,
  input logic          data_re,
  input logic          busy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  assert_no_store_in_sysreset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |-> !mem_we);

  assert_no_store_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_we);

  assert_fill_two_cycles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 !busy);

  assert_fill_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(reg_we) && $past(reg_sel) == 3'd5) || ($past(data_re) && !$past(sys_reset)));

  assert_sysreset_read_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_re && sys_reset && !busy && !reg_we) |=> !busy);
endmodule

bind vram_port vram_port_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .reg_we(reg_we),
  .reg_sel(reg_sel), .data_re(data_re), .busy(busy), .mem_we(mem_we),
  .mem_addr(mem_addr)
);

// File: tb/sim_vram_port.sv
module sim_vram_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_reset = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        data_we = 1'b0;
  logic [7:0]  data_wdata = '0;
  logic        data_re = 1'b0;
  logic [7:0]  data_rdata;
  logic        busy;
  logic [18:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  logic [7:0]  mem [0:4095];
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  vram_port u0 (
    .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .data_we(data_we),
    .data_wdata(data_wdata), .data_re(data_re), .data_rdata(data_rdata),
    .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 13 + 5) & 255);
  endfunction

  // op[12:11]: 0 reg write, 1 data write, 2 data read (data = expected)
  localparam logic [12:0] VEC [15] = '{
    {2'd0, 3'd3, 8'h10}, {2'd0, 3'd4, 8'h00}, {2'd0, 3'd5, 8'h00},
    {2'd2, 3'd0, 8'hD5}, {2'd2, 3'd0, 8'hE2},
    {2'd0, 3'd0, 8'h20}, {2'd0, 3'd1, 8'h00}, {2'd0, 3'd2, 8'h00},
    {2'd1, 3'd0, 8'hA5}, {2'd1, 3'd0, 8'h5A},
    {2'd0, 3'd3, 8'h20}, {2'd0, 3'd5, 8'h00},
    {2'd2, 3'd0, 8'hA5}, {2'd2, 3'd0, 8'h5A}, {2'd2, 3'd0, 8'hBF}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drain;
    while (busy) @(negedge clk);
  endtask

  task automatic step_reg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    drain();
  endtask

  task automatic step_wr(input logic [7:0] d, output logic we_seen, output logic [18:0] a_seen);
    @(negedge clk);
    data_we = 1'b1; data_wdata = d;
    #1;
    we_seen = mem_we; a_seen = mem_addr;
    @(negedge clk);
    data_we = 1'b0;
    drain();
  endtask

  task automatic step_rd(output logic [7:0] v);
    @(negedge clk);
    v = data_rdata;
    data_re = 1'b1;
    @(negedge clk);
    data_re = 1'b0;
    drain();
  endtask

  task automatic set_wptr(input logic [7:0] lo, input logic [7:0] mid, input logic [7:0] top);
    step_reg(3'd0, lo); step_reg(3'd1, mid); step_reg(3'd2, top);
  endtask

  task automatic set_rptr(input logic [7:0] lo, input logic [7:0] mid, input logic [7:0] top);
    step_reg(3'd3, lo); step_reg(3'd4, mid); step_reg(3'd5, top);
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    finish_up();
  end

  initial begin
    logic        we_s, b1, b2, b3;
    logic [18:0] a_s, a_t;
    logic [7:0]  v;
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 busy", busy, 0);
    check("R1 buffer", data_rdata, 8'h00);
    step_wr(8'h01, we_s, a_s);
    check("R1 store pointer", a_s, 19'h00000);
    check("R3 write enable", we_s, 1);

    for (int k = 0; k < 15; k++) begin
      logic [12:0] e;
      e = VEC[k];
      case (e[12:11])
        2'd0: step_reg(e[10:8], e[7:0]);
        2'd1: begin
          step_wr(e[7:0], we_s, a_s);
          check("R3 vector write", we_s, 1);
        end
        default: begin
          step_rd(v);
          check("R6 vector read", v, e[7:0]);
        end
      endcase
    end
    check("R3 mem 0x20", mem[12'h020], 8'hA5);
    check("R3 mem 0x21", mem[12'h021], 8'h5A);

    step_reg(3'd3, 8'h30); step_reg(3'd4, 8'h00);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd5; reg_wdata = 8'h80;
    @(negedge clk);
    reg_we = 1'b0; b1 = busy;
    @(negedge clk); b2 = busy;
    @(negedge clk); b3 = busy;
    check("R7 busy cycle1", b1, 1);
    check("R7 busy cycle2", b2, 1);
    check("R7 busy ends", b3, 0);
    check("R7 refill value", data_rdata, 8'h75);

    @(negedge clk);
    v = data_rdata; data_re = 1'b1;
    @(negedge clk);
    data_re = 1'b0; b1 = busy;
    check("R8 frozen read value", v, 8'h75);
    check("R8 no refill", b1, 0);
    step_rd(v);
    check("R8 pointer held", v, 8'h75);

    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd3; reg_wdata = 8'h60;
    @(negedge clk);
    reg_we = 1'b0; b1 = busy;
    check("R7 low byte no refill", b1, 0);
    check("R7 buffer kept", data_rdata, 8'h75);
    step_reg(3'd5, 8'h00);
    check("R7 top byte refill", data_rdata, 8'hE5);

    set_wptr(8'h40, 8'h00, 8'h80);
    step_wr(8'h11, we_s, a_s);
    step_wr(8'h22, we_s, a_t);
    check("R4 first addr", a_s, 19'h00040);
    check("R4 second addr", a_t, 19'h00040);
    check("R4 mem 0x40", mem[12'h040], 8'h22);
    check("R4 mem 0x41", mem[12'h041], pat(12'h041));

    set_wptr(8'h34, 8'h12, 8'hF5);
    step_wr(8'h3C, we_s, a_s);
    check("R2 top bits", a_s, 19'h51234);

    set_wptr(8'hFF, 8'h00, 8'h00);
    step_wr(8'h55, we_s, a_s);
    step_wr(8'h66, we_s, a_t);
    check("R5 low carry a", a_s, 19'h000FF);
    check("R5 low carry b", a_t, 19'h00100);
    set_wptr(8'hFF, 8'hFF, 8'h00);
    step_wr(8'h77, we_s, a_s);
    step_wr(8'h88, we_s, a_t);
    check("R5 mid carry a", a_s, 19'h0FFFF);
    check("R5 mid carry b", a_t, 19'h10000);
    set_wptr(8'hFF, 8'hFF, 8'h07);
    step_wr(8'h33, we_s, a_s);
    step_wr(8'h44, we_s, a_t);
    check("R5 wrap a", a_s, 19'h7FFFF);
    check("R5 wrap b", a_t, 19'h00000);

    set_rptr(8'h70, 8'h00, 8'h00);
    set_wptr(8'h71, 8'h00, 8'h00);
    step_rd(v);
    check("R9 first read", v, 8'hB5);
    step_wr(v, we_s, a_s);
    step_rd(v);
    check("R9 second read old data", v, 8'hC2);
    step_wr(v, we_s, a_s);
    check("R9 mem 0x71", mem[12'h071], 8'hB5);
    check("R9 mem 0x72", mem[12'h072], 8'hC2);

    set_rptr(8'h80, 8'h00, 8'h00);
    set_wptr(8'h90, 8'h00, 8'h00);
    @(negedge clk); sys_reset = 1'b1;
    step_wr(8'h99, we_s, a_s);
    check("R10 store dropped", we_s, 0);
    @(negedge clk);
    data_re = 1'b1;
    @(negedge clk);
    data_re = 1'b0; b1 = busy;
    check("R10 read no refill", b1, 0);
    check("R10 buffer kept", data_rdata, 8'h85);
    @(negedge clk); sys_reset = 1'b0;
    step_rd(v);
    check("R10 read pointer kept", v, 8'h85);
    step_rd(v);
    check("R10 next read", v, 8'h92);
    step_wr(8'hAB, we_s, a_s);
    check("R10 store pointer kept", a_s, 19'h00090);
    check("R10 mem untouched", mem[12'h091], pat(12'h091));

    set_wptr(8'hC8, 8'h00, 8'h00);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd5; reg_wdata = 8'h00;
    @(negedge clk);
    reg_we = 1'b0; data_we = 1'b1; data_wdata = 8'hEE;
    #1 we_s = mem_we;
    @(negedge clk);
    data_we = 1'b0;
    drain();
    check("R11 busy store dropped", we_s, 0);
    step_wr(8'h01, we_s, a_s);
    check("R11 pointer not stepped", a_s, 19'h000C8);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = 8'hD0;
    data_we = 1'b1; data_wdata = 8'hEF;
    #1 we_s = mem_we;
    @(negedge clk);
    reg_we = 1'b0; data_we = 1'b0;
    drain();
    check("R11 register wins", we_s, 0);
    step_wr(8'h02, we_s, a_s);
    check("R11 register loaded", a_s, 19'h000D0);

    finish_up();
  end
endmodule